// File: doc/BRIEF.md
# Differential High-Side Command Pulse Encoder

This block sits between low-voltage control logic and a pair of level-shifting channels that talk to a floating high-side gate driver. It takes an asynchronous, active-low request level for the high-side switch and sends it as short, timed pulses rather than as a level. When the request turns on, the block emits two equal pulses on a dedicated turn-on channel. When the request turns off, it emits a single pulse on a separate turn-off channel. Because the two commands use physically distinct channels, the receiving decoder can treat them as a differential pair and reject common-mode disturbances.

The request is synchronized with two flops, and the block then compares it with the last state it commanded. A change that arrives while a train is still in flight is not lost. Once the current train and its trailing gap have finished, the block sends a train for the latest level, and only if that level differs from what was last commanded. A supply-good input from an undervoltage monitor silences both channels immediately and aborts any train in progress. When that input is released, the block adopts the current request level without signalling it, so only later changes produce pulses. A busy flag marks the span of each train for neighbouring logic.

Top module: `hs_pulse_encoder`

## Requirements
- R1: During and after synchronous reset, `on_pulse`, `off_pulse` and `busy` are 0. Reset treats the request as inactive (`req_n` high) and the high-side as commanded off, so holding `req_n` high after reset produces no pulse.
- R2: `req_n` is active low. When the synchronized `req_n` falls, exactly two pulses appear on `on_pulse`, and `off_pulse` stays 0 for that train.
- R3: When the synchronized `req_n` rises, exactly one pulse appears on `off_pulse`, and `on_pulse` stays 0 for that train.
- R4: Each pulse is high for `PULSE_CYC` cycles, and every pulse is followed by `GAP_CYC` low cycles (defaults 4 and 4). The first pulse rises after the third rising clock edge that follows a `req_n` change: two synchronizer stages plus one decision register.
- R5: `on_pulse` and `off_pulse` are never 1 in the same cycle.
- R6: `busy` is 1 from the first pulse cycle through the last cycle of the trailing gap of a train, and 0 at all other times. A train therefore lasts 2*(PULSE_CYC+GAP_CYC) cycles for turn-on and PULSE_CYC+GAP_CYC cycles for turn-off.
- R7: A request change during a train is held. After the train ends there is one idle cycle with `busy` at 0, and then a train for the latest level starts if that level differs from the last commanded state. If the level has returned to the last commanded state, no train is sent.
- R8: While `uv_ok` is 0, the cycle after it is sampled low, and every cycle until it is sampled high again, has `on_pulse`, `off_pulse` and `busy` at 0. Any train in progress is abandoned.
- R9: After `uv_ok` returns to 1, no train is sent for the request level that was present during lockout. A later change of `req_n` produces its normal train.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_n | input | 1 | Asynchronous high-side request, low = switch on |
| uv_ok | input | 1 | Supply-good from the undervoltage monitor, 0 = lockout |
| on_pulse | output | 1 | Turn-on channel pulse |
| off_pulse | output | 1 | Turn-off channel pulse |
| busy | output | 1 | Pulse train in progress |

## Verification
The hardest cases to reach from the ports are the ones where the request moves while a train is still running. These include a reversal that cancels itself before the train ends, and a lockout that cuts a turn-on train after its first pulse. The stimulus reaches them by timing `req_n` and `uv_ok` changes a fixed number of cycles after the observed first pulse. It flips the request inside the gap of an on-train, toggles it twice inside an off-train, and drops the supply-good input mid-train. It then changes the request under lockout before releasing it. A behavioural queue model of the expected channel schedule is compared with the outputs on every cycle, and pulse counts per scenario confirm the train contents.

// File: rtl/hs_pulse_pkg.sv
package hs_pulse_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_HIGH = 2'd1,
    PH_LOW  = 2'd2
  } phase_t;

  localparam int unsigned ON_TRAIN_PULSES  = 2;
  localparam int unsigned OFF_TRAIN_PULSES = 1;
  localparam int unsigned LEFT_W           = 2;
endpackage

// File: rtl/hs_level_sync.sv
module hs_level_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= RST_VAL;
          else     chain[0] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[i] <= RST_VAL;
          else     chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/hs_cmd_tracker.sv
module hs_cmd_tracker (
  input  logic clk,
  input  logic rst,
  input  logic enable,
  input  logic req_n_sync,
  input  logic train_busy,
  output logic start,
  output logic start_on
);
  logic want_on;
  logic sent_on;

  assign want_on  = ~req_n_sync;
  assign start    = enable & ~train_busy & (want_on != sent_on);
  assign start_on = want_on;

  always_ff @(posedge clk) begin
    if (rst)          sent_on <= 1'b0;
    else if (!enable) sent_on <= want_on;
    else if (start)   sent_on <= want_on;
  end
endmodule

// File: rtl/hs_train_gen.sv
module hs_train_gen
  import hs_pulse_pkg::*;
#(
  parameter int unsigned PULSE_CYC = 4,
  parameter int unsigned GAP_CYC   = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic enable,
  input  logic start,
  input  logic start_on,
  output logic on_o,
  output logic off_o,
  output logic busy_o
);
  localparam int unsigned MAX_CYC = (PULSE_CYC > GAP_CYC) ? PULSE_CYC : GAP_CYC;
  localparam int unsigned CNT_W   = (MAX_CYC > 1) ? $clog2(MAX_CYC) : 1;
  localparam logic [CNT_W-1:0] HIGH_LAST = CNT_W'(PULSE_CYC - 1);
  localparam logic [CNT_W-1:0] LOW_LAST  = CNT_W'(GAP_CYC - 1);
  localparam logic [LEFT_W-1:0] ON_LEFT  = LEFT_W'(ON_TRAIN_PULSES - 1);
  localparam logic [LEFT_W-1:0] OFF_LEFT = LEFT_W'(OFF_TRAIN_PULSES - 1);

  phase_t            phase_q, phase_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [LEFT_W-1:0] left_q, left_d;
  logic              kind_on_q, kind_on_d;

  always_comb begin
    phase_d   = phase_q;
    cnt_d     = cnt_q;
    left_d    = left_q;
    kind_on_d = kind_on_q;
    if (!enable) begin
      phase_d = PH_IDLE;
      cnt_d   = '0;
      left_d  = '0;
    end else begin
      unique case (phase_q)
        PH_IDLE: begin
          if (start) begin
            phase_d   = PH_HIGH;
            cnt_d     = '0;
            kind_on_d = start_on;
            left_d    = start_on ? ON_LEFT : OFF_LEFT;
          end
        end
        PH_HIGH: begin
          if (cnt_q == HIGH_LAST) begin
            phase_d = PH_LOW;
            cnt_d   = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        PH_LOW: begin
          if (cnt_q == LOW_LAST) begin
            cnt_d = '0;
            if (left_q == '0) begin
              phase_d = PH_IDLE;
            end else begin
              phase_d = PH_HIGH;
              left_d  = left_q - 1'b1;
            end
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        default: phase_d = PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q   <= PH_IDLE;
      cnt_q     <= '0;
      left_q    <= '0;
      kind_on_q <= 1'b0;
      on_o      <= 1'b0;
      off_o     <= 1'b0;
      busy_o    <= 1'b0;
    end else begin
      phase_q   <= phase_d;
      cnt_q     <= cnt_d;
      left_q    <= left_d;
      kind_on_q <= kind_on_d;
      on_o      <= (phase_d == PH_HIGH) &  kind_on_d;
      off_o     <= (phase_d == PH_HIGH) & ~kind_on_d;
      busy_o    <= (phase_d != PH_IDLE);
    end
  end
endmodule

// File: rtl/hs_pulse_encoder.sv
module hs_pulse_encoder #(
  parameter int unsigned PULSE_CYC   = 4,
  parameter int unsigned GAP_CYC     = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic req_n,
  input  logic uv_ok,
  output logic on_pulse,
  output logic off_pulse,
  output logic busy
);
  logic req_n_s;
  logic start;
  logic start_on;

  hs_level_sync #(
    .STAGES  (SYNC_STAGES),
    .RST_VAL (1'b1)
  ) u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  (req_n),
    .dout (req_n_s)
  );

  hs_cmd_tracker u_track (
    .clk        (clk),
    .rst        (rst),
    .enable     (uv_ok),
    .req_n_sync (req_n_s),
    .train_busy (busy),
    .start      (start),
    .start_on   (start_on)
  );

  hs_train_gen #(
    .PULSE_CYC (PULSE_CYC),
    .GAP_CYC   (GAP_CYC)
  ) u_gen (
    .clk      (clk),
    .rst      (rst),
    .enable   (uv_ok),
    .start    (start),
    .start_on (start_on),
    .on_o     (on_pulse),
    .off_o    (off_pulse),
    .busy_o   (busy)
  );
endmodule

// File: rtl/hs_pulse_encoder_chk.sv
module hs_pulse_encoder_chk (
  input logic clk,
  input logic rst,
  input logic uv_ok,
  input logic on_pulse,
  input logic off_pulse,
  input logic busy
);
  AST_CHANNELS_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(on_pulse && off_pulse)); // R5

  AST_UV_SILENCES: assert property (@(posedge clk) disable iff (rst)
    !uv_ok |=> (!on_pulse && !off_pulse && !busy)); // R8

  AST_PULSE_INSIDE_TRAIN: assert property (@(posedge clk) disable iff (rst)
    (on_pulse || off_pulse) |-> busy); // R6

  AST_TRAIN_OPENS_HIGH: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> (on_pulse || off_pulse)); // R6

  AST_TRAIN_CLOSES_LOW: assert property (@(posedge clk) disable iff (rst)
    ($fell(busy) && $past(uv_ok)) |-> $past(!on_pulse && !off_pulse)); // R4
endmodule

bind hs_pulse_encoder hs_pulse_encoder_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .uv_ok     (uv_ok),
  .on_pulse  (on_pulse),
  .off_pulse (off_pulse),
  .busy      (busy)
);

// File: tb/hs_pulse_encoder_test.sv
`timescale 1ns/1ps
module hs_pulse_encoder_test;
  localparam int PW = 4;
  localparam int GW = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_n = 1'b1;
  logic uv_ok = 1'b1;
  logic on_pulse, off_pulse, busy;

  int tests = 0;
  int fails = 0;
  bit finished = 0;
  bit cmp_en = 0;

  always #10 clk = ~clk;

  hs_pulse_encoder #(.PULSE_CYC(PW), .GAP_CYC(GW), .SYNC_STAGES(2)) uut (
    .clk(clk), .rst(rst), .req_n(req_n), .uv_ok(uv_ok),
    .on_pulse(on_pulse), .off_pulse(off_pulse), .busy(busy)
  );

  // behavioural model: schedule queue of {busy, off, on}
  logic [2:0] sched[$];
  logic m_s1 = 1'b1, m_s2 = 1'b1, m_sent = 1'b0;
  logic [2:0] exp_v = 3'b000;

  always @(posedge clk) begin
    logic old_s2;
    old_s2 = m_s2;
    m_s2 = m_s1;
    m_s1 = req_n;
    if (rst) begin
      m_s1 = 1'b1; m_s2 = 1'b1; m_sent = 1'b0;
      sched.delete();
    end else if (!uv_ok) begin
      sched.delete();
      m_sent = ~old_s2;
    end else if (sched.size() > 0) begin
      void'(sched.pop_front());
    end else if ((~old_s2) != m_sent) begin
      m_sent = ~old_s2;
      for (int p = 0; p < (m_sent ? 2 : 1); p++) begin
        for (int c = 0; c < PW; c++) sched.push_back(m_sent ? 3'b101 : 3'b110);
        for (int c = 0; c < GW; c++) sched.push_back(3'b100);
      end
    end
    exp_v = (sched.size() > 0) ? sched[0] : 3'b000;
  end

  int on_rises = 0, off_rises = 0, both_high = 0;
  logic prev_on = 0, prev_off = 0;

  always @(negedge clk) begin
    if (cmp_en) begin
      tests++;
      if ({busy, off_pulse, on_pulse} !== exp_v) begin
        fails++;
        $display("FAIL R4 R6 per-cycle schedule: got busy/off/on=%b expected %b at %0t",
                 {busy, off_pulse, on_pulse}, exp_v, $time);
      end
      if (on_pulse && !prev_on) on_rises++;
      if (off_pulse && !prev_off) off_rises++;
      if (on_pulse && off_pulse) both_high++;
      prev_on = on_pulse;
      prev_off = off_pulse;
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clr();
    on_rises = 0; off_rises = 0;
  endtask

  task automatic check(input string req, input int got, input int want);
    tests++;
    if (got != want) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, got, want);
    end
  endtask

  task automatic wait_first_pulse();
    int guard = 0;
    while (!(on_pulse || off_pulse) && guard < 20) begin
      @(negedge clk); guard++;
    end
  endtask

  initial begin
    cyc(3);
    cmp_en = 1;
    // R1 reset state
    check("R1 on during reset", on_pulse, 0);
    check("R1 busy during reset", busy, 0);
    rst = 1'b0;
    cyc(20);
    check("R1 no pulse after reset", on_rises + off_rises, 0);

    // R2 turn-on train, R4 latency
    clr();
    req_n = 1'b0;
    cyc(2);
    check("R4 no pulse before third edge", on_pulse, 0);
    cyc(1);
    check("R4 pulse after third edge", on_pulse, 1);
    cyc(37);
    check("R2 on pulses", on_rises, 2);
    check("R2 off stays low", off_rises, 0);

    // R3 turn-off train
    clr();
    req_n = 1'b1;
    cyc(40);
    check("R3 off pulses", off_rises, 1);
    check("R3 on stays low", on_rises, 0);

    // R7 reversal inside the gap of an on train
    clr();
    req_n = 1'b0;
    wait_first_pulse();
    cyc(6);
    req_n = 1'b1;
    cyc(60);
    check("R7 on train kept", on_rises, 2);
    check("R7 pending off sent", off_rises, 1);

    // R7 double toggle inside an off train
    req_n = 1'b0;
    cyc(40);
    clr();
    req_n = 1'b1;
    wait_first_pulse();
    cyc(2);
    req_n = 1'b0;
    cyc(2);
    req_n = 1'b1;
    cyc(50);
    check("R7 off once", off_rises, 1);
    check("R7 cancelled toggle", on_rises, 0);

    // R8 lockout mid on-train
    clr();
    req_n = 1'b0;
    wait_first_pulse();
    cyc(5);
    uv_ok = 1'b0;
    cyc(1);
    check("R8 busy cleared", busy, 0);
    check("R8 on cleared", on_pulse, 0);
    req_n = 1'b1;
    cyc(10);
    check("R8 quiet in lockout", on_pulse | off_pulse | busy, 0);

    // R9 release without command
    clr();
    uv_ok = 1'b1;
    cyc(40);
    check("R9 no pulse at release", on_rises + off_rises, 0);
    req_n = 1'b0;
    cyc(40);
    check("R9 later edge on pulses", on_rises, 2);

    check("R5 never both", both_high, 0);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      tests++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule